// File: doc/BRIEF.md
# Guarded Loadable Counter Register

This block holds a single word that outside logic can load, increment and read. Three trigger inputs drive it: one for each of those commands. The triggers may come from logic that does not share the block's clock. Each one is first brought into the local clock domain and then screened for stability. Only after that can it take part in a decision. For load and increment, only the rising edge of the screened trigger counts as a command. A trigger that is held high therefore acts once.

A small arbiter inspects the screened commands on every cycle. If commands clash, it performs no operation and raises an error flag; it never quietly picks one command over another. A load that coincides with an increment is refused, and so is any cycle in which all three triggers are active. The read side is a plain level qualifier: the stored word appears on the output only while the screened read trigger is high.

Top module: `guarded_counter`

## Requirements
- R1: A synchronous reset clears the stored word to zero and drives the data output to zero, the valid qualifier low and the error flag low.
- R2: A rising edge of the screened load trigger copies the data input into the stored word.
- R3: A rising edge of the screened increment trigger adds one to the stored word. The all-ones value wraps to zero.
- R4: A trigger held high for a long stretch performs its load or increment exactly once.
- R5: A synchronized trigger level that differs from the current screened level for fewer than HOLD consecutive cycles has no effect. A level held for HOLD consecutive cycles or longer is accepted.
- R6: While the screened read trigger is high, the data output shows the stored word and the valid qualifier is high. Otherwise the data output is zero and valid is low.
- R7: When load and increment edges arrive in the same cycle, the stored word is left unchanged. The error flag goes high in the following cycle.
- R8: While all three screened triggers are high, no operation is performed, valid stays low and the error flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register in the block |
| rst | input | 1 | Synchronous reset, active high |
| loadTrig | input | 1 | Raw load command, may be asynchronous |
| incTrig | input | 1 | Raw increment command, may be asynchronous |
| readTrig | input | 1 | Raw read command, may be asynchronous |
| dataIn | input | WIDTH | Value captured on a load |
| dataOut | output | WIDTH | Stored word while reading, zero otherwise |
| dataValid | output | 1 | High while dataOut carries the stored word |
| errorFlag | output | 1 | High for each cycle in which conflicting commands were refused |

## Verification
The assertions assume that dataIn does not change while a load edge is working its way through the screening path. They also assume that the stored word changes only through the strobes from the control module. The bench therefore sets dataIn before it raises a load trigger and keeps it fixed until the trigger has dropped. Every raw trigger is changed only at the falling clock edge, and it is held for whole cycle counts: HOLD-1 cycles when a glitch is wanted, and well over HOLD cycles otherwise. This keeps the synchronizer and filter latency deterministic against the bench's settle windows.

// File: rtl/guarded_counter_pkg.sv
package guarded_counter_pkg;
  typedef struct packed {
    logic doLoad;
    logic doInc;
    logic show;
  } cmdStrobes_t;
endpackage

// File: rtl/trigger_conditioner.sv
module trigger_conditioner #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic syncA, syncB;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  // The screened level follows syncB after HOLD straight cycles of disagreement
  always_ff @(posedge clk) begin
    if (rst) begin
      filtOut <= 1'b0;
      runCnt  <= '0;
    end else if (syncB != filtOut) begin
      if (runCnt == LAST) begin
        filtOut <= syncB;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      runCnt <= '0;
    end
  end

  // R5
  filter_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (filtOut != $past(filtOut)) |-> (filtOut == $past(syncB)));
endmodule

// File: rtl/guarded_control.sv
module guarded_control
  import guarded_counter_pkg::*;
#(
  parameter int HOLD = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rawLoad,
  input  logic        rawInc,
  input  logic        rawRead,
  output cmdStrobes_t strobes,
  output logic        errorFlag
);
  localparam int NTRIG = 3;

  logic [NTRIG-1:0] rawVec, filtVec;
  logic loadPrev, incPrev;
  logic loadEdge, incEdge, allThree, clash;

  assign rawVec = {rawRead, rawInc, rawLoad};

  for (genvar i = 0; i < NTRIG; i++) begin : g_cond
    trigger_conditioner #(.HOLD(HOLD)) u_cond (
      .clk    (clk),
      .rst    (rst),
      .rawIn  (rawVec[i]),
      .filtOut(filtVec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loadPrev  <= 1'b0;
      incPrev   <= 1'b0;
      errorFlag <= 1'b0;
    end else begin
      loadPrev  <= filtVec[0];
      incPrev   <= filtVec[1];
      errorFlag <= allThree | clash;
    end
  end

  always_comb begin
    loadEdge = filtVec[0] & ~loadPrev;
    incEdge  = filtVec[1] & ~incPrev;
    allThree = &filtVec;
    clash    = loadEdge & incEdge;
    strobes.doLoad = loadEdge & ~clash & ~allThree;
    strobes.doInc  = incEdge & ~clash & ~allThree;
    strobes.show   = filtVec[2] & ~allThree;
  end

  // R7
  clash_flagged_chk: assert property (@(posedge clk) disable iff (rst)
    (loadEdge && incEdge) |=> errorFlag);

  // R4
  load_once_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.doLoad |=> !strobes.doLoad);
endmodule

// File: rtl/guarded_datapath.sv
module guarded_datapath
  import guarded_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  cmdStrobes_t      strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid
);
  logic [WIDTH-1:0] stored;

  always_ff @(posedge clk) begin
    if (rst)                 stored <= '0;
    else if (strobes.doLoad) stored <= dataIn;
    else if (strobes.doInc)  stored <= stored + 1'b1;
  end

  assign dataValid = strobes.show;
  assign dataOut   = strobes.show ? stored : '0;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.doLoad |=> (stored == $past(dataIn)));

  // R3
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.doInc && !strobes.doLoad) |=> (stored == $past(stored) + 1'b1));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.doInc && !strobes.doLoad) |=> $stable(stored));
endmodule

// File: rtl/guarded_counter.sv
module guarded_counter
  import guarded_counter_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int HOLD  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadTrig,
  input  logic             incTrig,
  input  logic             readTrig,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid,
  output logic             errorFlag
);
  cmdStrobes_t strobes;

  guarded_control #(.HOLD(HOLD)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rawLoad  (loadTrig),
    .rawInc   (incTrig),
    .rawRead  (readTrig),
    .strobes  (strobes),
    .errorFlag(errorFlag)
  );

  guarded_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

  // R6
  out_zero_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dataValid |-> (dataOut == '0));
endmodule

// File: tb/guarded_counter_tb.sv
module guarded_counter_tb;
  localparam int WIDTH  = 4;
  localparam int HOLD   = 3;
  localparam int SETTLE = HOLD + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadTrig = 1'b0, incTrig = 1'b0, readTrig = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic dataValid, errorFlag;

  int checks = 0;
  int fails  = 0;
  logic errSeen;

  always #10 clk = ~clk;

  guarded_counter #(.WIDTH(WIDTH), .HOLD(HOLD)) u_dut (
    .clk(clk), .rst(rst), .loadTrig(loadTrig), .incTrig(incTrig),
    .readTrig(readTrig), .dataIn(dataIn), .dataOut(dataOut),
    .dataValid(dataValid), .errorFlag(errorFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (errorFlag) errSeen = 1'b1;
    end
  endtask

  task automatic pulseLoad(input logic [WIDTH-1:0] v);
    @(negedge clk); dataIn = v; loadTrig = 1'b1;
    waitCyc(SETTLE);
    loadTrig = 1'b0;
    waitCyc(SETTLE);
  endtask

  task automatic pulseInc();
    @(negedge clk); incTrig = 1'b1;
    waitCyc(SETTLE);
    incTrig = 1'b0;
    waitCyc(SETTLE);
  endtask

  task automatic readCheck(input string req, input int exp);
    @(negedge clk); readTrig = 1'b1;
    waitCyc(SETTLE);
    chk(dataValid === 1'b1, req, int'(dataValid), 1);
    chk(dataOut === exp[WIDTH-1:0], req, int'(dataOut), exp);
    readTrig = 1'b0;
    waitCyc(SETTLE);
  endtask

  initial begin
    waitCyc(3);
    // R1: reset state
    chk(dataOut === '0 && dataValid === 1'b0 && errorFlag === 1'b0, "R1", int'(dataOut), 0);
    rst = 1'b0;
    waitCyc(2);
    readCheck("R1", 0);

    // R2: load every value
    for (int v = 0; v < (1 << WIDTH); v++) begin
      pulseLoad(v[WIDTH-1:0]);
      readCheck("R2", v);
    end

    // R3: increment sweep through the wrap
    pulseLoad('0);
    for (int k = 1; k <= (1 << WIDTH) + 1; k++) begin
      pulseInc();
      readCheck("R3", k % (1 << WIDTH));
    end

    // R4: held increment acts once
    pulseLoad(4'd5);
    @(negedge clk); incTrig = 1'b1;
    waitCyc(8 * SETTLE);
    incTrig = 1'b0;
    waitCyc(SETTLE);
    readCheck("R4", 6);

    // R5: short glitches ignored
    @(negedge clk); incTrig = 1'b1;
    waitCyc(HOLD - 1);
    incTrig = 1'b0;
    waitCyc(SETTLE);
    @(negedge clk); dataIn = 4'd12; loadTrig = 1'b1;
    waitCyc(HOLD - 1);
    loadTrig = 1'b0;
    waitCyc(SETTLE);
    readCheck("R5", 6);
    // R5: exactly HOLD cycles accepted
    @(negedge clk); incTrig = 1'b1;
    waitCyc(HOLD);
    incTrig = 1'b0;
    waitCyc(SETTLE);
    readCheck("R5", 7);

    // R6: no read gives zero and invalid
    waitCyc(2);
    chk(dataValid === 1'b0, "R6", int'(dataValid), 0);
    chk(dataOut === '0, "R6", int'(dataOut), 0);

    // R7: load and increment together refused
    errSeen = 1'b0;
    @(negedge clk); dataIn = 4'd2; loadTrig = 1'b1; incTrig = 1'b1;
    waitCyc(SETTLE);
    loadTrig = 1'b0; incTrig = 1'b0;
    waitCyc(SETTLE);
    chk(errSeen === 1'b1, "R7", int'(errSeen), 1);
    chk(errorFlag === 1'b0, "R7", int'(errorFlag), 0);
    readCheck("R7", 7);

    // R8: all three together
    @(negedge clk); readTrig = 1'b1;
    waitCyc(SETTLE);
    @(negedge clk); dataIn = 4'd9; loadTrig = 1'b1; incTrig = 1'b1;
    waitCyc(SETTLE);
    chk(dataValid === 1'b0, "R8", int'(dataValid), 0);
    chk(dataOut === '0, "R8", int'(dataOut), 0);
    chk(errorFlag === 1'b1, "R8", int'(errorFlag), 1);
    loadTrig = 1'b0; incTrig = 1'b0; readTrig = 1'b0;
    waitCyc(SETTLE);
    chk(errorFlag === 1'b0, "R8", int'(errorFlag), 0);
    readCheck("R8", 7);

    // R1: reset mid-run clears the word
    @(negedge clk); rst = 1'b1;
    waitCyc(2);
    chk(errorFlag === 1'b0 && dataValid === 1'b0, "R1", int'(errorFlag), 0);
    rst = 1'b0;
    waitCyc(2);
    readCheck("R1", 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule